// File: doc/BRIEF.md
# Multi-Channel Clock Frequency Meter

This block measures the frequency of one of four monitored clocks against a reference clock. Software writes a window length, a channel number and an enable bit into one control word. The meter then waits for the first rising edge of the chosen clock. From that edge it counts reference cycles until the chosen clock has completed the programmed number of further cycles. The count goes into a result register and a status flag tells software that the result is ready. Software polls the flag, reads the result, and works out the monitored frequency as `window * f_ref / result`.

A rising edge of each monitored clock flips a toggle flop in that clock's own domain. A two-flop synchronizer carries the toggle into the reference domain, where a change of level marks one monitored edge. Each channel has its own synchronizer, so changing the channel does not produce a false edge. A monitored clock therefore has to run at less than half the reference rate. A separate free-run enable in the status register gates all counting. A timeout guards against a channel that never toggles.

The register port is a plain single-cycle port in the reference domain. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational, with no handshake and no back-pressure. Reset is asynchronous and active low.

Top module: `fm_meter_top`

## Requirements
- R1: After reset every register reads zero. The control word, the result and the status register (valid flag and free-run enable) all read 0.
- R2: The control word at offset 0x00 holds the window in bits 23:0, the enable in bit 24 and the channel select in bits 27:26, and it reads back as written. The status word at offset 0x10 has a writable free-run enable in bit 8 and a read-only valid flag in bit 0. The result sits at offset 0x0C. Every other offset reads 0.
- R3: For a selected clock whose period is exactly P reference cycles, a window of W gives a result of W*P.
- R4: The channel select chooses which of the four monitored clocks is measured. Clocks with different periods give different results for the same window.
- R5: When the window completes, the valid flag (status bit 0) reads 1 and stays 1 until the next start or disable.
- R6: A write of the control word with bit 24 set starts a new measurement, even if one is already running or finished. The valid flag reads 0 from the cycle after that write.
- R7: Writing the control word with bit 24 clear stops the measurement. Valid reads 0 from the next cycle and no result arrives later. The previous result stays readable.
- R8: Counting of both reference cycles and monitored edges proceeds only while the enable and the free-run enable are both 1. With the free-run enable at 0 no measurement completes. Setting it later resumes the measurement and gives the correct result.
- R9: If a measurement has not completed after TIMEOUT_CYC counted reference cycles, it ends with result 0 and valid 1. With no monitored edges, valid reads 0 after TIMEOUT_CYC-1 cycles and 1 after TIMEOUT_CYC cycles, counted from the starting write.
- R10: A window of 0 ends the measurement one cycle after the start, with result 0 and valid 1.
- R11: The result register changes only when a measurement completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all register and counting logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | N_CH | Monitored clocks, one per channel |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk_ref |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |

## Verification
On every cycle the assertions check four things. A start clears the valid flag on the next cycle. A cleared enable keeps valid low. Valid only rises after a cycle in which both enables were set. The result register moves only together with a rising valid. The bench alone shows the arithmetic: the sweep runs three channels with known integer periods against a set of window lengths and compares each result with window times period. Its scenarios also show the exact cycle on which the timeout fires, the outcome of a zero window, the pause under a cleared free-run enable, the abort, and register readback.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_RESULT = 8'h0C;
  localparam logic [7:0] OFF_STATUS = 8'h10;

  localparam int CTRL_EN_BIT   = 24;
  localparam int CTRL_SEL_LSB  = 26;
  localparam int STAT_VLD_BIT  = 0;
  localparam int STAT_FRCK_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_chan_edge.sv
module fm_chan_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic clk_ref,
  input  logic rst_n,
  output logic edge_pulse
);
  logic                   tgl;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tgl};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_pulse = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int WIN_W  = 24,
  parameter int RES_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [RES_W-1:0]  result,
  input  logic              valid,
  output logic [WIN_W-1:0]  win,
  output logic              en,
  output logic [1:0]        sel,
  output logic              frck,
  output logic              start
);
  logic ctrl_hit, stat_hit;
  logic unused_wbits;

  assign ctrl_hit = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign stat_hit = bus_wr && (bus_addr == ADDR_W'(OFF_STATUS));
  assign start    = ctrl_hit && bus_wdata[CTRL_EN_BIT];
  assign unused_wbits = ^{bus_wdata[DATA_W-1:28], bus_wdata[25]};

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      en   <= 1'b0;
      sel  <= '0;
      frck <= 1'b0;
    end else begin
      if (ctrl_hit) begin
        win <= bus_wdata[WIN_W-1:0];
        en  <= bus_wdata[CTRL_EN_BIT];
        sel <= bus_wdata[CTRL_SEL_LSB +: 2];
      end
      if (stat_hit) frck <= bus_wdata[STAT_FRCK_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      bus_rdata[WIN_W-1:0]             = win;
      bus_rdata[CTRL_EN_BIT]           = en;
      bus_rdata[CTRL_SEL_LSB +: 2]     = sel;
    end else if (bus_addr == ADDR_W'(OFF_RESULT)) begin
      bus_rdata[RES_W-1:0]             = result;
    end else if (bus_addr == ADDR_W'(OFF_STATUS)) begin
      bus_rdata[STAT_VLD_BIT]          = valid;
      bus_rdata[STAT_FRCK_BIT]         = frck;
    end
  end
endmodule

// File: rtl/fm_core.sv
module fm_core
  import fm_pkg::*;
#(
  parameter int WIN_W       = 24,
  parameter int RES_W       = 32,
  parameter int TIMEOUT_CYC = 65536
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic             frck,
  input  logic [WIN_W-1:0] win,
  input  logic             edge_in,
  output logic [RES_W-1:0] result,
  output logic             valid
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  fm_state_e        state;
  logic [RES_W-1:0] ref_cnt;
  logic [WIN_W-1:0] mon_cnt;
  logic [TMO_W-1:0] tmo;
  logic [RES_W-1:0] ref_nxt;
  logic [WIN_W-1:0] mon_nxt;
  logic             tmo_hit;

  assign ref_nxt = ref_cnt + RES_W'(1);
  assign mon_nxt = mon_cnt + WIN_W'(1);
  assign tmo_hit = (tmo == TMO_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ref_cnt <= '0;
      mon_cnt <= '0;
      tmo     <= '0;
      result  <= '0;
      valid   <= 1'b0;
    end else if (start) begin
      state   <= ST_ARM;
      valid   <= 1'b0;
      ref_cnt <= '0;
      mon_cnt <= '0;
      tmo     <= '0;
    end else if (!en) begin
      state <= ST_IDLE;
      valid <= 1'b0;
    end else if (frck) begin
      unique case (state)
        ST_ARM: begin
          tmo <= tmo + TMO_W'(1);
          if (win == '0) begin
            state  <= ST_DONE;
            result <= '0;
            valid  <= 1'b1;
          end else if (edge_in) begin
            state <= ST_RUN;
          end else if (tmo_hit) begin
            state  <= ST_DONE;
            result <= '0;
            valid  <= 1'b1;
          end
        end
        ST_RUN: begin
          ref_cnt <= ref_nxt;
          tmo     <= tmo + TMO_W'(1);
          if (edge_in) mon_cnt <= mon_nxt;
          if (edge_in && (mon_nxt == win)) begin
            state  <= ST_DONE;
            result <= ref_nxt;
            valid  <= 1'b1;
          end else if (tmo_hit) begin
            state  <= ST_DONE;
            result <= '0;
            valid  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fm_meter_top.sv
module fm_meter_top #(
  parameter int N_CH        = 4,
  parameter int WIN_W       = 24,
  parameter int RES_W       = 32,
  parameter int TIMEOUT_CYC = 65536,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   mon_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [N_CH-1:0]  ch_edge;
  logic             sel_edge;
  logic [WIN_W-1:0] ctrl_win;
  logic             ctrl_en;
  logic [1:0]       ctrl_sel;
  logic             frck_en;
  logic             start_pulse;
  logic [RES_W-1:0] meas_result;
  logic             meas_valid;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    fm_chan_edge #(.SYNC_STAGES(2)) u_edge (
      .mon_clk   (mon_clk[i]),
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .edge_pulse(ch_edge[i])
    );
  end

  always_comb begin
    sel_edge = 1'b0;
    for (int i = 0; i < N_CH; i++)
      if (ctrl_sel == 2'(i)) sel_edge = ch_edge[i];
  end

  fm_regs #(
    .WIN_W(WIN_W), .RES_W(RES_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .result   (meas_result),
    .valid    (meas_valid),
    .win      (ctrl_win),
    .en       (ctrl_en),
    .sel      (ctrl_sel),
    .frck     (frck_en),
    .start    (start_pulse)
  );

  fm_core #(
    .WIN_W(WIN_W), .RES_W(RES_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_core (
    .clk_ref(clk_ref),
    .rst_n  (rst_n),
    .start  (start_pulse),
    .en     (ctrl_en),
    .frck   (frck_en),
    .win    (ctrl_win),
    .edge_in(sel_edge),
    .result (meas_result),
    .valid  (meas_valid)
  );
endmodule

// File: rtl/fm_meter_chk.sv
module fm_meter_chk #(
  parameter int RES_W = 32
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             start,
  input logic             en,
  input logic             frck,
  input logic             valid,
  input logic [RES_W-1:0] result
);
  // R6
  start_clears_valid_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    start |=> !valid);

  // R7
  disable_keeps_valid_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!en && !start) |=> !valid);

  // R8
  valid_needs_both_enables_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(valid) |-> $past(en && frck));

  // R11
  result_moves_on_done_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(result) |-> $rose(valid));
endmodule

bind fm_meter_top fm_meter_chk #(.RES_W(RES_W)) u_chk (
  .clk_ref(clk_ref),
  .rst_n  (rst_n),
  .start  (start_pulse),
  .en     (ctrl_en),
  .frck   (frck_en),
  .valid  (meas_valid),
  .result (meas_result)
);

// File: tb/tb_fm_meter_top.sv
`timescale 1ns/1ps
module tb_fm_meter_top;
  localparam int TMO = 512;
  localparam logic [7:0] A_CTRL = 8'h00, A_RES = 8'h0C, A_STAT = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m0 = 1'b0, m1 = 1'b0, m2 = 1'b0;
  logic [3:0]  mon;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign mon = {1'b0, m2, m1, m0};

  always #2.5 clk = ~clk;
  // channel periods in reference cycles: 4, 6, 10; channel 3 is dead
  initial begin #1; forever #10 m0 = ~m0; end
  initial begin #1; forever #15 m1 = ~m1; end
  initial begin #1; forever #25 m2 = ~m2; end

  fm_meter_top #(.TIMEOUT_CYC(TMO)) dut (
    .clk_ref(clk), .rst_n(rst_n), .mon_clk(mon),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic int period_of(int ch);
    case (ch) 0: return 4; 1: return 6; 2: return 10; default: return 0; endcase
  endfunction

  function automatic logic [31:0] ctrl_word(int ch, bit en, int win);
    return (32'(ch) << 26) | (32'(en) << 24) | (32'(win) & 32'h00FF_FFFF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_valid(int limit, output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      rd(A_STAT, s);
      if (s[0]) begin ok = 1; break; end
    end
  endtask

  task automatic measure(int ch, int win, string req);
    bit ok;
    logic [31:0] r;
    wr(A_CTRL, ctrl_word(ch, 1'b1, win));
    wait_valid(win * period_of(ch) + 50, ok);
    check(req, 32'(ok), 32'd1);
    rd(A_RES, r);
    check(req, r, 32'(win * period_of(ch)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, keep;
    bit ok;
    int wins[7] = '{1, 2, 3, 4, 7, 16, 33};
    repeat (10) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); check("R1", d, 32'h0);
    rd(A_RES, d);  check("R1", d, 32'h0);
    rd(A_STAT, d); check("R1", d, 32'h0);

    // R2 readback and field layout
    wr(A_CTRL, ctrl_word(2, 1'b0, 24'hABCDE));
    rd(A_CTRL, d); check("R2", d, 32'h080A_BCDE);
    wr(A_STAT, 32'h0000_0101);
    rd(A_STAT, d); check("R2", d, 32'h0000_0100);
    rd(8'h04, d);  check("R2", d, 32'h0);

    // R3 R4 R5 sweep over channels and windows
    for (int ch = 0; ch < 3; ch++)
      for (int k = 0; k < 7; k++)
        measure(ch, wins[k], "R3_R4_R5");

    // R11 result held while idle
    rd(A_RES, keep);
    repeat (100) @(negedge clk);
    rd(A_RES, d); check("R11", d, keep);
    rd(A_STAT, d); check("R5", 32'(d[0]), 32'd1);

    // R6 restart clears valid
    measure(1, 3, "R6");
    wr(A_CTRL, ctrl_word(0, 1'b1, 2));
    rd(A_STAT, d); check("R6", 32'(d[0]), 32'd0);
    wait_valid(100, ok); check("R6", 32'(ok), 32'd1);
    rd(A_RES, d); check("R6", d, 32'd8);

    // R7 abort keeps old result
    measure(0, 5, "R7");
    wr(A_CTRL, ctrl_word(2, 1'b1, 100));
    repeat (50) @(negedge clk);
    wr(A_CTRL, ctrl_word(2, 1'b0, 100));
    rd(A_STAT, d); check("R7", 32'(d[0]), 32'd0);
    repeat (1200) @(negedge clk);
    rd(A_STAT, d); check("R7", 32'(d[0]), 32'd0);
    rd(A_RES, d);  check("R7", d, 32'd20);

    // R8 free-run enable gates counting
    wr(A_STAT, 32'h0);
    wr(A_CTRL, ctrl_word(0, 1'b1, 4));
    repeat (TMO + 100) @(negedge clk);
    rd(A_STAT, d); check("R8", 32'(d[0]), 32'd0);
    rd(A_RES, d);  check("R8", d, 32'd20);
    wr(A_STAT, 32'h100);
    wait_valid(100, ok); check("R8", 32'(ok), 32'd1);
    rd(A_RES, d);  check("R8", d, 32'd16);

    // R9 timeout on a dead channel, exact cycle
    wr(A_CTRL, ctrl_word(3, 1'b1, 4));
    repeat (TMO - 1) @(posedge clk);
    #1;
    rd(A_STAT, d); check("R9", 32'(d[0]), 32'd0);
    @(posedge clk); #1;
    rd(A_STAT, d); check("R9", 32'(d[0]), 32'd1);
    rd(A_RES, d);  check("R9", d, 32'd0);

    // R10 zero window
    measure(2, 2, "R10");
    wr(A_CTRL, ctrl_word(0, 1'b1, 0));
    rd(A_STAT, d); check("R10", 32'(d[0]), 32'd0);
    @(posedge clk); #1;
    rd(A_STAT, d); check("R10", 32'(d[0]), 32'd1);
    rd(A_RES, d);  check("R10", d, 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule